// File: doc/BRIEF.md
# Phase-Aligned Multi-Bank Clock Divider

This block turns a fast stream of source steps into three banks of divided clocks: five lines in bank A, four in bank B and two in bank C. Everything runs in one system clock domain. The oscillator and the external reference each arrive as a one-cycle step pulse. A bypass input picks which of the two pulses advances the divider chain. An optional range stage lets only every second source step through. The steps that come out of this stage are the divider steps.

All three banks take their phase from one shared step counter. The counter wraps after 12 steps, which is the least common multiple of the selectable ratios. Each bank derives a 50% waveform from the counter position using its own ratio. Because the position is shared, every bank rises on the same divider step whenever their periods meet.

A combined disable input forces every clock line low and clears all divider state. An output-enable flag drops at the same time, which models the high-impedance state. Changes on the ratio selects and the range select are taken in only at the step that starts a new 12-step cycle, so no runt pulse can appear.

Top module: `multibank_clkdiv`

## Requirements
- R1: While `rst` is high, and on the edge after it, `out_en` is 0 and every clock line is 0.
- R2: With `range_sel` at 0, each source step is a divider step. With `range_sel` at 1, only the first of every two source steps is a divider step, counting from release or from the start of a 12-step cycle.
- R3: Bank A divides by 4 when `sel_a` is 0 and by 6 when `sel_a` is 1. It is high for the first half of its period and low for the second half.
- R4: Bank B divides by 4 when `sel_b` is 0 and by 2 when `sel_b` is 1, with a 50% duty cycle.
- R5: Bank C divides by 2 when `sel_c` is 0 and by 4 when `sel_c` is 1, with a 50% duty cycle.
- R6: `hold_off` at 1 clears all divider state. On the next edge it also drives `out_en` and every clock line to 0. With `hold_off` and `rst` both at 0, `out_en` is 1 after the next edge.
- R7: The first divider step after release drives every clock line high on the same edge.
- R8: With `bypass` at 1, `ref_step` advances the dividers and `osc_step` is ignored. With `bypass` at 0, the roles are reversed.
- R9: Step k of the shared cycle (k = 0..11) drives a bank with ratio N to 1 exactly when (k mod N) < N/2. At k = 0 every line rises together. All lines of one bank are always identical.
- R10: The select inputs (`sel_a`, `sel_b`, `sel_c`, `range_sel`) are sampled only at step k = 0, and also while the block is cleared. Changes at any other time take effect at the next k = 0.
- R11: Clock lines change only on edges where a divider step occurs, or where the block is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_step | input | 1 | One-cycle step pulse from the oscillator |
| ref_step | input | 1 | One-cycle step pulse from the reference |
| bypass | input | 1 | 1 selects ref_step as the divider source |
| range_sel | input | 1 | 1 halves the step rate ahead of the banks |
| sel_a | input | 1 | Bank A ratio: 0 gives /4, 1 gives /6 |
| sel_b | input | 1 | Bank B ratio: 0 gives /4, 1 gives /2 |
| sel_c | input | 1 | Bank C ratio: 0 gives /2, 1 gives /4 |
| hold_off | input | 1 | Combined disable and divider clear |
| out_en | output | 1 | High while the clock lines are driven |
| clk_a | output | 5 | Bank A clock lines |
| clk_b | output | 4 | Bank B clock lines |
| clk_c | output | 2 | Bank C clock lines |

## Verification
The assertions assume that step pulses are sampled on the system clock and that a step lasts one clock cycle when treated as an advance. The bench therefore changes every input only on the falling edge. It may raise `osc_step` or `ref_step` on any cycle, including on consecutive cycles, and the assertions are built to hold for any such pattern. Select changes and one-cycle disable pulses are placed at arbitrary points, not only at cycle boundaries, so the boundary loading is exercised. A behavioural model, built on integer step counts, predicts every output on each cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef struct packed {
    logic rng;
    logic sel_a;
    logic sel_b;
    logic sel_c;
  } div_cfg_t;

  function automatic int gcd2(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm2(input int a, input int b);
    return (a / gcd2(a, b)) * b;
  endfunction

  function automatic int lcm6(input int a, input int b, input int c,
                              input int d, input int e, input int f);
    return lcm2(lcm2(lcm2(a, b), lcm2(c, d)), lcm2(e, f));
  endfunction

endpackage

// File: rtl/step_prescale.sv
module step_prescale (
  input  logic clk,
  input  logic clr,
  input  logic adv,
  input  logic rng_q,
  input  logic nxt_rng,
  output logic tick
);
  logic skip_q;

  // a source step becomes a divider step unless halving skips it
  assign tick = adv && (!rng_q || !skip_q);

  always_ff @(posedge clk) begin
    if (clr)       skip_q <= 1'b0;
    else if (tick) skip_q <= nxt_rng;
    else if (adv)  skip_q <= 1'b0;
  end

  // halving mode: a divider step is never followed at once by another
  assert_half_rate_R2: assert property (@(posedge clk) disable iff (clr)
    (tick && nxt_rng) |=> !tick);

endmodule

// File: rtl/phase_counter.sv
module phase_counter
  import clkdiv_pkg::*;
#(
  parameter int CYCLE = 12,
  localparam int CW = (CYCLE > 1) ? $clog2(CYCLE) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          tick,
  input  div_cfg_t      cfg_in,
  output logic [CW-1:0] pos,
  output div_cfg_t      cfg_use,
  output logic          rng_q
);
  localparam logic [CW-1:0] LAST = CW'(CYCLE - 1);

  div_cfg_t cfg_q;
  logic     wrap;

  assign wrap    = (pos == '0);
  assign cfg_use = wrap ? cfg_in : cfg_q;
  assign rng_q   = cfg_q.rng;

  always_ff @(posedge clk) begin
    if (clr) begin
      pos   <= '0;
      cfg_q <= cfg_in;
    end else if (tick) begin
      pos   <= (pos == LAST) ? '0 : pos + 1'b1;
      cfg_q <= cfg_use;
    end
  end

  assert_pos_bound_R9: assert property (@(posedge clk) disable iff (clr)
    pos <= LAST);

  // mid-cycle steps keep the latched configuration
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (clr)
    (tick && !wrap) |=> $stable(cfg_q));

endmodule

// File: rtl/bank_driver.sv
module bank_driver #(
  parameter int WIDTH = 4,
  parameter int DIV0  = 4,
  parameter int DIV1  = 2,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             tick,
  input  logic             sel,
  input  logic [CW-1:0]    pos,
  output logic [WIDTH-1:0] q
);
  logic        lvl;
  int unsigned d;

  always_comb begin
    d   = sel ? DIV1 : DIV0;
    lvl = ((32'(pos) % d) < (d / 2));
  end

  // one flop per line so each output is registered locally
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (clr)       q[i] <= 1'b0;
      else if (tick) q[i] <= lvl;
    end
  end

  assert_cleared_R6: assert property (@(posedge clk)
    clr |=> (q == '0));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (clr)
    !tick |=> $stable(q));

endmodule

// File: rtl/multibank_clkdiv.sv
module multibank_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int A_WIDTH = 5,
  parameter int B_WIDTH = 4,
  parameter int C_WIDTH = 2,
  parameter int A_DIV0  = 4,
  parameter int A_DIV1  = 6,
  parameter int B_DIV0  = 4,
  parameter int B_DIV1  = 2,
  parameter int C_DIV0  = 2,
  parameter int C_DIV1  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               osc_step,
  input  logic               ref_step,
  input  logic               bypass,
  input  logic               range_sel,
  input  logic               sel_a,
  input  logic               sel_b,
  input  logic               sel_c,
  input  logic               hold_off,
  output logic               out_en,
  output logic [A_WIDTH-1:0] clk_a,
  output logic [B_WIDTH-1:0] clk_b,
  output logic [C_WIDTH-1:0] clk_c
);
  localparam int CYCLE = lcm6(A_DIV0, A_DIV1, B_DIV0, B_DIV1, C_DIV0, C_DIV1);
  localparam int CW    = (CYCLE > 1) ? $clog2(CYCLE) : 1;

  logic          clr;
  logic          adv;
  logic          tick;
  logic          rng_q;
  logic [CW-1:0] pos;
  div_cfg_t      cfg_in;
  div_cfg_t      cfg_use;

  assign clr    = rst || hold_off;
  assign adv    = bypass ? ref_step : osc_step;
  assign cfg_in = '{rng: range_sel, sel_a: sel_a, sel_b: sel_b, sel_c: sel_c};

  step_prescale u_pre (
    .clk     (clk),
    .clr     (clr),
    .adv     (adv),
    .rng_q   (rng_q),
    .nxt_rng (cfg_use.rng),
    .tick    (tick)
  );

  phase_counter #(.CYCLE(CYCLE)) u_cnt (
    .clk     (clk),
    .clr     (clr),
    .tick    (tick),
    .cfg_in  (cfg_in),
    .pos     (pos),
    .cfg_use (cfg_use),
    .rng_q   (rng_q)
  );

  bank_driver #(.WIDTH(A_WIDTH), .DIV0(A_DIV0), .DIV1(A_DIV1), .CW(CW)) u_bank_a (
    .clk (clk), .clr (clr), .tick (tick), .sel (cfg_use.sel_a), .pos (pos), .q (clk_a)
  );

  bank_driver #(.WIDTH(B_WIDTH), .DIV0(B_DIV0), .DIV1(B_DIV1), .CW(CW)) u_bank_b (
    .clk (clk), .clr (clr), .tick (tick), .sel (cfg_use.sel_b), .pos (pos), .q (clk_b)
  );

  bank_driver #(.WIDTH(C_WIDTH), .DIV0(C_DIV0), .DIV1(C_DIV1), .CW(CW)) u_bank_c (
    .clk (clk), .clr (clr), .tick (tick), .sel (cfg_use.sel_c), .pos (pos), .q (clk_c)
  );

  always_ff @(posedge clk) begin
    if (clr) out_en <= 1'b0;
    else     out_en <= 1'b1;
  end

  assert_idle_low_R1: assert property (@(posedge clk)
    !out_en |-> ({clk_a, clk_b, clk_c} == '0));

  assert_cycle_rise_R9: assert property (@(posedge clk) disable iff (clr)
    (tick && pos == '0) |=> (&{clk_a, clk_b, clk_c}));

endmodule

// File: tb/test_multibank_clkdiv.sv
module test_multibank_clkdiv;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_step = 1'b0, ref_step = 1'b0, bypass = 1'b0;
  logic       range_sel = 1'b0, sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
  logic       hold_off = 1'b0;
  logic       out_en;
  logic [4:0] clk_a;
  logic [3:0] clk_b;
  logic [1:0] clk_c;

  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  multibank_clkdiv i_multibank_clkdiv (
    .clk(clk), .rst(rst), .osc_step(osc_step), .ref_step(ref_step),
    .bypass(bypass), .range_sel(range_sel), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c(sel_c), .hold_off(hold_off), .out_en(out_en),
    .clk_a(clk_a), .clk_b(clk_b), .clk_c(clk_c)
  );

  // behavioural reference: integer step index and latched ratios
  int   m_k = 0, m_da = 4, m_db = 4, m_dc = 2;
  bit   m_rng = 0, m_skip = 0, m_oe = 0;
  logic [4:0] e_a = '0;
  logic [3:0] e_b = '0;
  logic [1:0] e_c = '0;

  function automatic bit half_hi(int k, int d);
    return (k % d) < (d / 2);
  endfunction

  always @(posedge clk) begin
    bit adv;
    if (rst || hold_off) begin
      m_oe = 0; e_a = '0; e_b = '0; e_c = '0; m_k = 0; m_skip = 0;
      m_rng = range_sel;
    end else begin
      m_oe = 1;
      adv = bypass ? ref_step : osc_step;
      if (adv) begin
        if (m_skip) m_skip = 0;
        else begin
          if (m_k == 0) begin
            m_rng = range_sel;
            m_da = sel_a ? 6 : 4;
            m_db = sel_b ? 2 : 4;
            m_dc = sel_c ? 4 : 2;
          end
          e_a = {5{half_hi(m_k, m_da)}};
          e_b = {4{half_hi(m_k, m_db)}};
          e_c = {2{half_hi(m_k, m_dc)}};
          m_k = (m_k + 1) % 12;
          m_skip = m_rng;
        end
      end
    end
  end

  task automatic compare();
    logic [11:0] act, exp;
    act = {out_en, clk_a, clk_b, clk_c};
    exp = {m_oe, e_a, e_b, e_c};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_val(string req, logic [11:0] act, logic [11:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare on the falling edge, then drive fresh inputs
  task automatic cyc(bit o, bit r);
    @(negedge clk);
    compare();
    osc_step = o;
    ref_step = r;
  endtask

  task automatic run(int n, int dens_o, int dens_r);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 100) < dens_o, ($urandom % 100) < dens_r);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) cyc(1, 1);
    check_val("R1", {out_en, clk_a, clk_b, clk_c}, 12'h000);
    rst = 1'b0;
    hold_off = 1'b1;
    tag = "R6";
    repeat (3) cyc(1, 0);
    check_val("R6", {out_en, clk_a, clk_b, clk_c}, 12'h000);
    // release with a step on the first live edge
    hold_off = 1'b0;
    osc_step = 1'b1;
    @(negedge clk);
    check_val("R7", {out_en, clk_a, clk_b, clk_c}, 12'hFFF);
    compare();
    tag = "R3"; run(60, 100, 0);
    sel_a = 1'b1; tag = "R10"; run(7, 100, 0);
    tag = "R3"; run(60, 100, 0);
    sel_b = 1'b1; tag = "R4"; run(60, 100, 0);
    sel_c = 1'b1; tag = "R5"; run(60, 100, 0);
    sel_b = 1'b0; tag = "R10"; run(40, 40, 0);
    range_sel = 1'b1; tag = "R2"; run(120, 100, 0);
    run(120, 50, 0);
    range_sel = 1'b0;
    bypass = 1'b1; tag = "R8"; run(300, 90, 30);
    bypass = 1'b0; run(200, 35, 95);
    tag = "R11"; run(300, 8, 8);
    tag = "R6";
    for (int j = 0; j < 30; j++) begin
      run(5 + ($urandom % 20), 70, 0);
      @(negedge clk);
      compare();
      hold_off = 1'b1;
      osc_step = ($urandom % 2) == 1;
      @(negedge clk);
      check_val("R6", {out_en, clk_a, clk_b, clk_c}, 12'h000);
      compare();
      hold_off = 1'b0;
    end
    tag = "R9";
    for (int j = 0; j < 120; j++) begin
      sel_a = $urandom % 2; sel_b = $urandom % 2;
      sel_c = $urandom % 2; range_sel = $urandom % 2;
      bypass = ($urandom % 4) == 0;
      run(17, 80, 60);
    end
    tag = "R1";
    rst = 1'b1;
    cyc(1, 1);
    @(negedge clk);
    check_val("R1", {out_en, clk_a, clk_b, clk_c}, 12'h000);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule